// File: doc/BRIEF.md
# FM Synthesizer Host Register Bank

This block is the host-facing register bank and channel control of a six-channel synthesizer with two operators per channel. Each channel has a modulator operator and a carrier operator. The host drives a single byte-wide port. One port address selects the target register and the other carries the data for it. Behind the port sit three sets of registers. The first is an eight-byte custom instrument patch. The second holds the per-channel pitch (F-number, octave block) and the key and sustain controls. The third holds the per-channel instrument number and volume.

The bank unpacks the custom patch bytes into named per-operator fields. These fields are presented on every channel whose instrument number is 0. A channel that selects any other instrument shows zeroed patch fields, so that a downstream preset store can supply them. The bank also turns key transitions into one-cycle start and release strobes for each operator slot. Slot 2c is the modulator of channel c and slot 2c+1 is its carrier. All decoded values and strobes change on the clock edge that accepts the data write.

Top module: `fmRegBank`

## Requirements
- R1: A port write with `wrSel`=0 latches the low 6 bits of `wrData` as the register address. Bits 7:6 are dropped. A write with `wrSel`=1 stores `wrData` into the register at the latched address. The latched address stays in place across any number of data writes.
- R2: Registers 0x00 to 0x07 hold custom patch bytes 0 to 7. A write to one of them changes, in the same cycle, the decoded fields of every channel whose instrument number is 0. Channels with any other instrument number are left untouched.
- R3: Patch byte 0 (modulator) and byte 1 (carrier) each carry amplitude-vibrato enable in bit 7, pitch-vibrato enable in bit 6, sustained envelope type in bit 5, key-scale-rate in bit 4 and the frequency multiplier in bits 3:0. The bench reads the four flags as the 4-bit value {am,pm,egType,ksr}.
- R4: Byte 2 gives the modulator key-scale level (bits 7:6) and the modulator total level (bits 5:0). Byte 3 gives the carrier key-scale level (bits 7:6), the carrier half-wave select (bit 4), the modulator half-wave select (bit 3) and the channel feedback (bits 2:0).
- R5: Byte 4 and byte 5 give attack rate (bits 7:4) and decay rate (bits 3:0) for the modulator and the carrier. Byte 6 and byte 7 give sustain level (bits 7:4) and release rate (bits 3:0) for the modulator and the carrier.
- R6: Register 0x10+c sets F-number bits 7:0 of channel c. In register 0x20+c, bit 0 is F-number bit 8, bits 3:1 are the block and bit 5 is sustain.
- R7: Register 0x30+c sets the instrument number of channel c from bits 7:4 and the volume from bits 3:0. The carrier total level is volume×4. When the instrument number is 0, the modulator total level comes from the patch.
- R8: While a channel's instrument number is nonzero, all of its patch-derived outputs read 0: flags, multiplier, key-scale level, half-wave, rates, modulator total level and feedback. The carrier total level still follows the volume.
- R9: Bit 4 of register 0x20+c is the key. Writing key=1 while the stored key of channel c is 0 pulses `keyOnStb` for slots 2c and 2c+1 for exactly one cycle. Writing key=1 again while the key is already 1 gives no pulse.
- R10: Writing key=0 while the stored key is 1 pulses `keyOffStb` for slot 2c+1 (the carrier) only, for one cycle. The modulator bit never pulses. Writing key=0 while the key is already 0 gives no pulse.
- R11: Reset clears the latched address and every register. Every output then reads 0 and every channel is keyed off with instrument 0. A data write after reset without a new address goes to register 0x00.
- R12: Addresses with no register (0x08 to 0x0F, and 0x16 to 0x1F, 0x26 to 0x2F, 0x36 to 0x3F) ignore data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Port write enable |
| wrSel | input | 1 | 0: address write, 1: data write |
| wrData | input | 8 | Port write byte |
| chFnum | output | 54 | 9-bit F-number per channel |
| chBlock | output | 18 | 3-bit block per channel |
| chSustain | output | 6 | Sustain flag per channel |
| chInst | output | 24 | 4-bit instrument number per channel |
| chFeedback | output | 18 | 3-bit modulator feedback per channel |
| slotAm | output | 12 | Amplitude vibrato enable per slot |
| slotPm | output | 12 | Pitch vibrato enable per slot |
| slotEgType | output | 12 | Sustained envelope type per slot |
| slotKsr | output | 12 | Key-scale-rate flag per slot |
| slotMult | output | 48 | 4-bit frequency multiplier per slot |
| slotKsl | output | 24 | 2-bit key-scale level per slot |
| slotTl | output | 72 | 6-bit total level per slot |
| slotWave | output | 12 | Half-wave select per slot |
| slotAr | output | 48 | 4-bit attack rate per slot |
| slotDr | output | 48 | 4-bit decay rate per slot |
| slotSl | output | 48 | 4-bit sustain level per slot |
| slotRr | output | 48 | 4-bit release rate per slot |
| keyOnStb | output | 12 | One-cycle operator start strobe per slot |
| keyOffStb | output | 12 | One-cycle operator release strobe per slot |

## Verification
The address latch and all registers load on the rising edge that accepts the port write. Every decoded field is therefore valid one edge after the data write. The key strobes are registered on that same edge and drop again at the next edge. The bench drives inputs on falling edges and reads results at the falling edge right after the accepting rising edge. It checks strobe clearing one further falling edge later. The vector table puts each write and the field it should change in one row, so every expected value is due at a single fixed point.

// File: rtl/fmRegPkg.sv
package fmRegPkg;

  localparam int FM_CH       = 6;
  localparam int FM_SLOTS    = 2 * FM_CH;
  localparam int PATCH_BYTES = 8;
  localparam int ADDR_W      = 6;
  localparam int DATA_W      = 8;
  localparam int PIDX_W      = $clog2(PATCH_BYTES);
  localparam int FNUM_W      = 9;
  localparam int FLO_W       = 8;
  localparam int BLOCK_W     = 3;
  localparam int NIB_W       = 4;
  localparam int TL_W        = 6;
  localparam int KSL_W       = 2;
  localparam int FB_W        = 3;
  localparam int VOL_SHIFT   = TL_W - NIB_W;

  // Unpacked operator parameters
  typedef struct packed {
    logic             am;
    logic             pm;
    logic             egType;
    logic             ksr;
    logic [NIB_W-1:0] mult;
    logic [KSL_W-1:0] ksl;
    logic             wave;
    logic [NIB_W-1:0] ar;
    logic [NIB_W-1:0] dr;
    logic [NIB_W-1:0] sl;
    logic [NIB_W-1:0] rr;
  } fmOp_t;

  // Whole custom voice after unpacking
  typedef struct packed {
    fmOp_t            modOp;
    fmOp_t            carOp;
    logic [TL_W-1:0]  modTl;
    logic [FB_W-1:0]  fb;
  } fmPatch_t;

  // Control-to-datapath write strobes (one-hot target plus payload)
  typedef struct packed {
    logic [PATCH_BYTES-1:0] patchSel;
    logic [FM_CH-1:0]       fLoSel;
    logic [FM_CH-1:0]       fHiSel;
    logic [FM_CH-1:0]       insVolSel;
    logic [DATA_W-1:0]      data;
  } fmWrStb_t;

  // Merge one packed patch byte into the unpacked voice
  function automatic fmPatch_t applyPatchByte(fmPatch_t cur, logic [PIDX_W-1:0] idx,
                                              logic [DATA_W-1:0] b);
    fmPatch_t nxt;
    nxt = cur;
    case (idx)
      3'd0: begin
        nxt.modOp.am     = b[7];
        nxt.modOp.pm     = b[6];
        nxt.modOp.egType = b[5];
        nxt.modOp.ksr    = b[4];
        nxt.modOp.mult   = b[3:0];
      end
      3'd1: begin
        nxt.carOp.am     = b[7];
        nxt.carOp.pm     = b[6];
        nxt.carOp.egType = b[5];
        nxt.carOp.ksr    = b[4];
        nxt.carOp.mult   = b[3:0];
      end
      3'd2: begin
        nxt.modOp.ksl = b[7:6];
        nxt.modTl     = b[5:0];
      end
      3'd3: begin
        nxt.carOp.ksl  = b[7:6];
        nxt.carOp.wave = b[4];
        nxt.modOp.wave = b[3];
        nxt.fb         = b[2:0];
      end
      3'd4: begin
        nxt.modOp.ar = b[7:4];
        nxt.modOp.dr = b[3:0];
      end
      3'd5: begin
        nxt.carOp.ar = b[7:4];
        nxt.carOp.dr = b[3:0];
      end
      3'd6: begin
        nxt.modOp.sl = b[7:4];
        nxt.modOp.rr = b[3:0];
      end
      3'd7: begin
        nxt.carOp.sl = b[7:4];
        nxt.carOp.rr = b[3:0];
      end
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/fmRegCtrl.sv
module fmRegCtrl
  import fmRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output fmWrStb_t          stb
);

  logic [ADDR_W-1:0] addrQ;

  // Register address latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (wrEn && !wrSel) begin
      addrQ <= wrData[ADDR_W-1:0];
    end
  end

  // Address decode: group in bits 5:4, index in bits 3:0
  always_comb begin
    stb      = '0;
    stb.data = wrData;
    if (wrEn && wrSel) begin
      case (addrQ[5:4])
        2'd0: if (!addrQ[3]) stb.patchSel[addrQ[PIDX_W-1:0]] = 1'b1;
        2'd1: for (int c = 0; c < FM_CH; c++) if (addrQ[3:0] == 4'(c)) stb.fLoSel[c] = 1'b1;
        2'd2: for (int c = 0; c < FM_CH; c++) if (addrQ[3:0] == 4'(c)) stb.fHiSel[c] = 1'b1;
        2'd3: for (int c = 0; c < FM_CH; c++) if (addrQ[3:0] == 4'(c)) stb.insVolSel[c] = 1'b1;
      endcase
    end
  end

  logic [PATCH_BYTES+3*FM_CH-1:0] allSel;
  assign allSel = {stb.patchSel, stb.fLoSel, stb.fHiSel, stb.insVolSel};

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> addrQ == $past(wrData[ADDR_W-1:0])); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && !wrSel) |=> $stable(addrQ)); // R1
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allSel)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrSel) |-> allSel == '0); // R1

endmodule

// File: rtl/fmRegData.sv
module fmRegData
  import fmRegPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  fmWrStb_t                     stb,
  output logic [FM_CH*FNUM_W-1:0]      chFnum,
  output logic [FM_CH*BLOCK_W-1:0]     chBlock,
  output logic [FM_CH-1:0]             chSustain,
  output logic [FM_CH*NIB_W-1:0]       chInst,
  output logic [FM_CH*FB_W-1:0]        chFeedback,
  output logic [FM_SLOTS-1:0]          slotAm,
  output logic [FM_SLOTS-1:0]          slotPm,
  output logic [FM_SLOTS-1:0]          slotEgType,
  output logic [FM_SLOTS-1:0]          slotKsr,
  output logic [FM_SLOTS*NIB_W-1:0]    slotMult,
  output logic [FM_SLOTS*KSL_W-1:0]    slotKsl,
  output logic [FM_SLOTS*TL_W-1:0]     slotTl,
  output logic [FM_SLOTS-1:0]          slotWave,
  output logic [FM_SLOTS*NIB_W-1:0]    slotAr,
  output logic [FM_SLOTS*NIB_W-1:0]    slotDr,
  output logic [FM_SLOTS*NIB_W-1:0]    slotSl,
  output logic [FM_SLOTS*NIB_W-1:0]    slotRr,
  output logic [FM_SLOTS-1:0]          keyOnStb,
  output logic [FM_SLOTS-1:0]          keyOffStb
);

  fmPatch_t           customQ;
  logic [FLO_W-1:0]   fLoQ   [FM_CH];
  logic               fnHiQ  [FM_CH];
  logic [BLOCK_W-1:0] blockQ [FM_CH];
  logic               susQ   [FM_CH];
  logic [NIB_W-1:0]   insQ   [FM_CH];
  logic [NIB_W-1:0]   volQ   [FM_CH];
  logic [FM_CH-1:0]   keyQ;
  logic [FM_SLOTS-1:0] keyOnQ;
  logic [FM_SLOTS-1:0] keyOffQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      customQ <= '0;
      keyQ    <= '0;
      keyOnQ  <= '0;
      keyOffQ <= '0;
      for (int c = 0; c < FM_CH; c++) begin
        fLoQ[c]   <= '0;
        fnHiQ[c]  <= 1'b0;
        blockQ[c] <= '0;
        susQ[c]   <= 1'b0;
        insQ[c]   <= '0;
        volQ[c]   <= '0;
      end
    end else begin
      keyOnQ  <= '0;
      keyOffQ <= '0;
      for (int k = 0; k < PATCH_BYTES; k++) begin
        if (stb.patchSel[k]) customQ <= applyPatchByte(customQ, PIDX_W'(k), stb.data);
      end
      for (int c = 0; c < FM_CH; c++) begin
        if (stb.fLoSel[c]) fLoQ[c] <= stb.data;
        if (stb.fHiSel[c]) begin
          fnHiQ[c]  <= stb.data[0];
          blockQ[c] <= stb.data[3:1];
          susQ[c]   <= stb.data[5];
          keyQ[c]   <= stb.data[4];
          if (stb.data[4] && !keyQ[c]) begin
            keyOnQ[2*c]   <= 1'b1;
            keyOnQ[2*c+1] <= 1'b1;
          end
          if (!stb.data[4] && keyQ[c]) begin
            keyOffQ[2*c+1] <= 1'b1;
          end
        end
        if (stb.insVolSel[c]) begin
          insQ[c] <= stb.data[7:4];
          volQ[c] <= stb.data[3:0];
        end
      end
    end
  end

  assign keyOnStb  = keyOnQ;
  assign keyOffStb = keyOffQ;

  for (genvar c = 0; c < FM_CH; c++) begin : gCh
    fmPatch_t chPatch;
    assign chPatch = (insQ[c] == '0) ? customQ : '0;

    assign chFnum[c*FNUM_W +: FNUM_W]    = {fnHiQ[c], fLoQ[c]};
    assign chBlock[c*BLOCK_W +: BLOCK_W] = blockQ[c];
    assign chSustain[c]                  = susQ[c];
    assign chInst[c*NIB_W +: NIB_W]      = insQ[c];
    assign chFeedback[c*FB_W +: FB_W]    = chPatch.fb;

    for (genvar k = 0; k < 2; k++) begin : gOp
      localparam int S = 2 * c + k;
      fmOp_t op;
      assign op = (k == 0) ? chPatch.modOp : chPatch.carOp;
      assign slotAm[S]                  = op.am;
      assign slotPm[S]                  = op.pm;
      assign slotEgType[S]              = op.egType;
      assign slotKsr[S]                 = op.ksr;
      assign slotMult[S*NIB_W +: NIB_W] = op.mult;
      assign slotKsl[S*KSL_W +: KSL_W]  = op.ksl;
      assign slotWave[S]                = op.wave;
      assign slotAr[S*NIB_W +: NIB_W]   = op.ar;
      assign slotDr[S*NIB_W +: NIB_W]   = op.dr;
      assign slotSl[S*NIB_W +: NIB_W]   = op.sl;
      assign slotRr[S*NIB_W +: NIB_W]   = op.rr;
      assign slotTl[S*TL_W +: TL_W]     = (k == 0) ? chPatch.modTl
                                                   : {volQ[c], {VOL_SHIFT{1'b0}}};
    end

    AST_KEYON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
      keyOnQ[2*c+1] |-> (keyQ[c] && !$past(keyQ[c]))); // R9
    AST_KEYON_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      keyOnQ[2*c] |=> !keyOnQ[2*c]); // R9
    AST_KEYOFF_EDGE: assert property (@(posedge clk) disable iff (!rstN)
      keyOffQ[2*c+1] |-> (!keyQ[c] && $past(keyQ[c]))); // R10
    AST_FOREIGN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (insQ[c] != '0) |-> (slotAr[(2*c+1)*NIB_W +: NIB_W] == '0 &&
                           slotTl[(2*c)*TL_W +: TL_W] == '0 &&
                           chFeedback[c*FB_W +: FB_W] == '0)); // R8
  end

  AST_NO_ON_OFF_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    (keyOnQ & keyOffQ) == '0); // R10

endmodule

// File: rtl/fmRegBank.sv
module fmRegBank
  import fmRegPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         wrSel,
  input  logic [DATA_W-1:0]            wrData,
  output logic [FM_CH*FNUM_W-1:0]      chFnum,
  output logic [FM_CH*BLOCK_W-1:0]     chBlock,
  output logic [FM_CH-1:0]             chSustain,
  output logic [FM_CH*NIB_W-1:0]       chInst,
  output logic [FM_CH*FB_W-1:0]        chFeedback,
  output logic [FM_SLOTS-1:0]          slotAm,
  output logic [FM_SLOTS-1:0]          slotPm,
  output logic [FM_SLOTS-1:0]          slotEgType,
  output logic [FM_SLOTS-1:0]          slotKsr,
  output logic [FM_SLOTS*NIB_W-1:0]    slotMult,
  output logic [FM_SLOTS*KSL_W-1:0]    slotKsl,
  output logic [FM_SLOTS*TL_W-1:0]     slotTl,
  output logic [FM_SLOTS-1:0]          slotWave,
  output logic [FM_SLOTS*NIB_W-1:0]    slotAr,
  output logic [FM_SLOTS*NIB_W-1:0]    slotDr,
  output logic [FM_SLOTS*NIB_W-1:0]    slotSl,
  output logic [FM_SLOTS*NIB_W-1:0]    slotRr,
  output logic [FM_SLOTS-1:0]          keyOnStb,
  output logic [FM_SLOTS-1:0]          keyOffStb
);

  fmWrStb_t wrStb;

  fmRegCtrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .stb    (wrStb)
  );

  fmRegData data_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (wrStb),
    .chFnum     (chFnum),
    .chBlock    (chBlock),
    .chSustain  (chSustain),
    .chInst     (chInst),
    .chFeedback (chFeedback),
    .slotAm     (slotAm),
    .slotPm     (slotPm),
    .slotEgType (slotEgType),
    .slotKsr    (slotKsr),
    .slotMult   (slotMult),
    .slotKsl    (slotKsl),
    .slotTl     (slotTl),
    .slotWave   (slotWave),
    .slotAr     (slotAr),
    .slotDr     (slotDr),
    .slotSl     (slotSl),
    .slotRr     (slotRr),
    .keyOnStb   (keyOnStb),
    .keyOffStb  (keyOffStb)
  );

endmodule

// File: tb/fmRegBank_tb.sv
`timescale 1ns/1ps
module fmRegBank_tb_top;
  import fmRegPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [DATA_W-1:0] wrData = '0;

  logic [FM_CH*FNUM_W-1:0]   chFnum;
  logic [FM_CH*BLOCK_W-1:0]  chBlock;
  logic [FM_CH-1:0]          chSustain;
  logic [FM_CH*NIB_W-1:0]    chInst;
  logic [FM_CH*FB_W-1:0]     chFeedback;
  logic [FM_SLOTS-1:0]       slotAm, slotPm, slotEgType, slotKsr, slotWave;
  logic [FM_SLOTS*NIB_W-1:0] slotMult, slotAr, slotDr, slotSl, slotRr;
  logic [FM_SLOTS*KSL_W-1:0] slotKsl;
  logic [FM_SLOTS*TL_W-1:0]  slotTl;
  logic [FM_SLOTS-1:0]       keyOnStb, keyOffStb;

  fmRegBank dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .chFnum(chFnum), .chBlock(chBlock), .chSustain(chSustain), .chInst(chInst),
    .chFeedback(chFeedback), .slotAm(slotAm), .slotPm(slotPm), .slotEgType(slotEgType),
    .slotKsr(slotKsr), .slotMult(slotMult), .slotKsl(slotKsl), .slotTl(slotTl),
    .slotWave(slotWave), .slotAr(slotAr), .slotDr(slotDr), .slotSl(slotSl),
    .slotRr(slotRr), .keyOnStb(keyOnStb), .keyOffStb(keyOffStb)
  );

  always #4 clk = ~clk;  // 125 MHz

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  localparam int WATCHDOG = 20000;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      nFail = nFail + 1;
      $display("FAIL watchdog (all requirements): got %0d cycles, expected fewer", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input int req, input logic [15:0] got, input logic [15:0] exp,
                     input string what);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive one port access on a falling edge; returns at the falling edge
  // that follows the accepting rising edge.
  task automatic portWr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  // Address bytes carry junk in bits 7:6 to exercise the mask (R1)
  task automatic regWr(input logic [5:0] a, input logic [7:0] d);
    portWr(1'b0, {2'b11, a});
    portWr(1'b1, d);
  endtask

  function automatic logic [15:0] obs(input int sel, input int idx);
    case (sel)
      0:  return 16'(chFnum[idx*FNUM_W +: FNUM_W]);
      1:  return 16'(chBlock[idx*BLOCK_W +: BLOCK_W]);
      2:  return 16'(chSustain[idx]);
      3:  return 16'(chInst[idx*NIB_W +: NIB_W]);
      4:  return 16'(chFeedback[idx*FB_W +: FB_W]);
      5:  return 16'(slotTl[idx*TL_W +: TL_W]);
      6:  return 16'(slotMult[idx*NIB_W +: NIB_W]);
      7:  return 16'(slotAr[idx*NIB_W +: NIB_W]);
      8:  return 16'(slotDr[idx*NIB_W +: NIB_W]);
      9:  return 16'(slotSl[idx*NIB_W +: NIB_W]);
      10: return 16'(slotRr[idx*NIB_W +: NIB_W]);
      11: return 16'(slotKsl[idx*KSL_W +: KSL_W]);
      12: return 16'(slotWave[idx]);
      13: return 16'({slotAm[idx], slotPm[idx], slotEgType[idx], slotKsr[idx]});
      default: return 16'hDEAD;
    endcase
  endfunction

  // {req, addr, data, observe-select, index, expected}
  localparam int NV = 42;
  localparam logic [41:0] VEC [NV] = '{
    {4'd3,  6'h00, 8'hA5, 4'd13, 4'd0,  16'h000A},  // R3 mod flags
    {4'd2,  6'h00, 8'hA5, 4'd6,  4'd10, 16'h0005},  // R2 other channel sees patch
    {4'd3,  6'h00, 8'hA5, 4'd6,  4'd0,  16'h0005},  // R3 mod mult
    {4'd3,  6'h01, 8'h5C, 4'd13, 4'd1,  16'h0005},  // R3 car flags
    {4'd3,  6'h01, 8'h5C, 4'd6,  4'd1,  16'h000C},  // R3 car mult
    {4'd2,  6'h01, 8'h5C, 4'd13, 4'd11, 16'h0005},  // R2
    {4'd4,  6'h02, 8'hC7, 4'd11, 4'd0,  16'h0003},  // R4 mod ksl
    {4'd4,  6'h02, 8'hC7, 4'd5,  4'd0,  16'h0007},  // R4 mod tl
    {4'd2,  6'h02, 8'hC7, 4'd5,  4'd8,  16'h0007},  // R2
    {4'd4,  6'h03, 8'h9D, 4'd11, 4'd1,  16'h0002},  // R4 car ksl
    {4'd4,  6'h03, 8'h9D, 4'd12, 4'd1,  16'h0001},  // R4 car wave
    {4'd4,  6'h03, 8'h9D, 4'd12, 4'd0,  16'h0001},  // R4 mod wave
    {4'd4,  6'h03, 8'h9D, 4'd4,  4'd0,  16'h0005},  // R4 feedback
    {4'd5,  6'h04, 8'h3E, 4'd7,  4'd0,  16'h0003},  // R5
    {4'd5,  6'h04, 8'h3E, 4'd8,  4'd0,  16'h000E},
    {4'd5,  6'h05, 8'hF1, 4'd7,  4'd1,  16'h000F},
    {4'd5,  6'h05, 8'hF1, 4'd8,  4'd1,  16'h0001},
    {4'd5,  6'h06, 8'h28, 4'd9,  4'd0,  16'h0002},
    {4'd5,  6'h06, 8'h28, 4'd10, 4'd0,  16'h0008},
    {4'd5,  6'h07, 8'h96, 4'd9,  4'd3,  16'h0009},
    {4'd5,  6'h07, 8'h96, 4'd10, 4'd3,  16'h0006},
    {4'd6,  6'h13, 8'hAB, 4'd0,  4'd3,  16'h00AB},  // R6
    {4'd6,  6'h23, 8'h2D, 4'd0,  4'd3,  16'h01AB},
    {4'd6,  6'h23, 8'h2D, 4'd1,  4'd3,  16'h0006},
    {4'd6,  6'h23, 8'h2D, 4'd2,  4'd3,  16'h0001},
    {4'd7,  6'h32, 8'h0B, 4'd5,  4'd5,  16'h002C},  // R7 vol x4
    {4'd7,  6'h32, 8'h0B, 4'd3,  4'd2,  16'h0000},
    {4'd7,  6'h32, 8'h0B, 4'd5,  4'd4,  16'h0007},
    {4'd8,  6'h34, 8'h79, 4'd3,  4'd4,  16'h0007},  // R8
    {4'd8,  6'h34, 8'h79, 4'd5,  4'd9,  16'h0024},
    {4'd8,  6'h34, 8'h79, 4'd13, 4'd8,  16'h0000},
    {4'd8,  6'h34, 8'h79, 4'd6,  4'd9,  16'h0000},
    {4'd8,  6'h34, 8'h79, 4'd4,  4'd4,  16'h0000},
    {4'd8,  6'h34, 8'h79, 4'd5,  4'd8,  16'h0000},
    {4'd2,  6'h00, 8'hFF, 4'd13, 4'd0,  16'h000F},  // R2 re-apply
    {4'd8,  6'h00, 8'hFF, 4'd13, 4'd8,  16'h0000},  // R8 not re-applied
    {4'd7,  6'h34, 8'h09, 4'd13, 4'd8,  16'h000F},  // R7 back to custom
    {4'd7,  6'h34, 8'h09, 4'd5,  4'd9,  16'h0024},
    {4'd12, 6'h08, 8'h00, 4'd13, 4'd0,  16'h000F},  // R12 holes ignored
    {4'd12, 6'h18, 8'h77, 4'd0,  4'd0,  16'h0000},
    {4'd12, 6'h38, 8'h50, 4'd3,  4'd0,  16'h0000},
    {4'd12, 6'h28, 8'h20, 4'd2,  4'd0,  16'h0000}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(11, 16'(chFnum == '0),    16'd1, "fnum clear after reset");
    chk(11, 16'(chInst == '0),    16'd1, "instrument clear after reset");
    chk(11, 16'(slotTl == '0),    16'd1, "total level clear after reset");
    chk(11, 16'(keyOnStb),        16'd0, "no key-on in reset");
    chk(11, 16'(keyOffStb),       16'd0, "no key-off in reset");
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      regWr(v[37:32], v[31:24]);
      chk(int'(v[41:38]), obs(int'(v[23:20]), int'(v[19:16])), v[15:0],
          $sformatf("vector %0d", i));
    end

    // R1 address persistence across two data writes, masked address
    portWr(1'b0, 8'h54);
    portWr(1'b1, 8'h11);
    chk(1, obs(0, 4), 16'h0011, "data to latched 0x14");
    portWr(1'b1, 8'h22);
    chk(1, obs(0, 4), 16'h0022, "second data to same latch");

    // R9 key-on on channel 1: both slots, one cycle
    regWr(6'h21, 8'h10);
    chk(9, 16'(keyOnStb),  16'h00C, "key-on slots 2,3");
    chk(10, 16'(keyOffStb), 16'h000, "no release on key-on");
    @(negedge clk);
    chk(9, 16'(keyOnStb),  16'h000, "key-on strobe single cycle");
    regWr(6'h21, 8'h12);
    chk(9, 16'(keyOnStb),  16'h000, "repeat key-on no strobe");
    chk(6, obs(1, 1),      16'h0001, "block ch1");
    // R10 key-off carrier only
    regWr(6'h21, 8'h02);
    chk(10, 16'(keyOffStb), 16'h008, "release carrier slot 3 only");
    chk(9, 16'(keyOnStb),   16'h000, "no key-on on key-off");
    @(negedge clk);
    chk(10, 16'(keyOffStb), 16'h000, "release strobe single cycle");
    regWr(6'h21, 8'h00);
    chk(10, 16'(keyOffStb), 16'h000, "repeat key-off no strobe");
    regWr(6'h25, 8'h30);
    chk(9, 16'(keyOnStb),   16'hC00, "key-on slots 10,11");
    chk(6, obs(2, 5),       16'h0001, "sustain ch5");

    // R11 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(11, 16'(chFnum == '0), 16'd1, "fnum cleared by reset");
    chk(11, 16'(chInst == '0), 16'd1, "instrument cleared by reset");
    rstN = 1'b1;
    portWr(1'b1, 8'h0F);
    chk(11, obs(6, 0), 16'h000F, "address latch back to 0x00");
    chk(11, obs(6, 2), 16'h000F, "patch on channel 1 after reset");
    regWr(6'h25, 8'h10);
    chk(11, 16'(keyOnStb), 16'hC00, "key state cleared by reset");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule